// File: doc/BRIEF.md
# Halt Wake-up and Reset Status Controller

This controller sequences a processor core through power-down and restart. A halt command from the running core parks the controller in a halted state. There the core clock enable drops and four wake sources are watched: the external reset pin, the watchdog overflow, a falling edge on any port pin whose wake-mask bit is set, and a fresh interrupt request. Every restart, whether a reset or a wake, passes through a fixed start-up wait before the core runs again. A new reset that arrives during that wait starts it over.

Two status flags let software tell the restart causes apart. The timeout flag records watchdog trips. The sleep flag records that the part went through halt. Each cause sets or clears them by a fixed rule. A watchdog wake from halt asks the core for a warm reset, which restores only the program counter and stack pointer. Reset sources in normal run ask for a full reset. A port or interrupt wake resumes the program. An interrupt wake jumps to the vector only when that interrupt is enabled and the stack has room.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While power_on is high, core_run=0, full_reset=1, tmo_flag=0 and sleep_flag=0. core_run rises on the START_DELAY-th clock edge after the last edge that saw power_on high.
- R2: halt_cmd while running moves the block to halt on the next edge. There core_run=0, sys_clk_en=0, sleep_flag=1 and tmo_flag=0.
- R3: wdt_clear_cmd while running clears sleep_flag on the next edge and leaves tmo_flag unchanged.
- R4: ext_rst_n low outside halt gives full_reset=1 and leaves both flags unchanged. core_run rises START_DELAY edges after the last edge that saw ext_rst_n low.
- R5: ext_rst_n low during halt gives full_reset=1, tmo_flag=0 and sleep_flag=1.
- R6: wdt_timeout outside halt gives full_reset=1 and tmo_flag=1, with sleep_flag unchanged.
- R7: wdt_timeout during halt gives warm_reset=1 and full_reset=0 for the whole start-up wait, with tmo_flag=1 and sleep_flag=1.
- R8: During halt, a falling edge (1 then 0 on consecutive edges) on port pin i wakes the block when port_wake_mask[i]=1. Such a wake raises neither reset output nor take_interrupt. With mask bit 0, the falling edge and a later rising edge leave core_run and sys_clk_en low.
- R9: An interrupt wake (irq_req going high in halt) makes take_interrupt=1 in the first cycle of core_run=1 only if irq_en=1 and stack_full=0. Otherwise take_interrupt stays 0.
- R10: If irq_req is already high when halt is entered, it does not wake the block while it stays high. After it drops and rises again, it does wake the block.
- R11: For a wake, core_run rises on the START_DELAY-th edge after the edge that registered the wake cause. A second reset during the wait reloads the full wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| power_on | input | 1 | Power-up reset, active high, synchronous |
| ext_rst_n | input | 1 | External reset pin, active low, synchronous |
| halt_cmd | input | 1 | Core requests power-down |
| wdt_clear_cmd | input | 1 | Core clears the watchdog |
| wdt_timeout | input | 1 | Watchdog overflow |
| port_pins | input | PORT_W | Port input levels |
| port_wake_mask | input | PORT_W | Per-pin wake enable |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable |
| stack_full | input | 1 | Return stack has no free slot |
| core_run | output | 1 | Core may execute |
| sys_clk_en | output | 1 | Core clock enable, low during halt |
| full_reset | output | 1 | Full core reset during the start-up wait |
| warm_reset | output | 1 | PC/SP-only reset during the start-up wait |
| take_interrupt | output | 1 | Vector to the interrupt on resume |
| tmo_flag | output | 1 | Watchdog timeout status |
| sleep_flag | output | 1 | Halt-entered status |

## Verification
The halt state and the status flags appear one edge after the command or reset that sets them. The bench reads them at the falling edge right after that rising edge. core_run rises START_DELAY edges after the edge that registered the cause. For a reset pulse driven over one edge, the bench counts START_DELAY edges from the moment it releases the pulse. For a pin or interrupt wake, it counts START_DELAY+1 edges from the moment it drives the input, because the first of those edges is the one that registers the wake. take_interrupt is sampled in that same first running cycle. Ignored stimuli are followed by several idle cycles before core_run and sys_clk_en are checked.

// File: rtl/hwc_pkg.sv
// Shared types for the halt/wake controller.
package hwc_pkg;
    typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_START} hwc_state_t;
    typedef enum logic [1:0] {RK_NONE, RK_FULL, RK_WARM} rst_kind_t;
endpackage

// File: rtl/hwc_startup_timer.sv
// Start-up wait counter.
// Loads DELAY-1 on power_on or load, then counts down to zero.
// done is high when the count has reached zero and no reload is pending.
// Assumes DELAY >= 1.
module hwc_startup_timer #(
    parameter int DELAY = 1024
) (
    input  logic clk,
    input  logic power_on,
    input  logic load,
    output logic done
);
    localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY - 1);

    logic [CW-1:0] cnt;

    // Reload on a cause, otherwise step down until zero.
    always_ff @(posedge clk) begin
        if (power_on || load)
            cnt <= LOAD_VAL;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Wait is over once the count is at zero with no reload this cycle.
    assign done = (cnt == '0) && !load && !power_on;

    AST_LOAD_FULL: assert property (@(posedge clk) disable iff (power_on)
        load |=> (cnt == LOAD_VAL)); // R11
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (power_on)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1))); // R11
endmodule

// File: rtl/hwc_port_wake.sv
// Port falling-edge detector.
// Keeps a registered copy of the pins and flags any masked pin that went from 1 to 0.
// Assumes the pins are already synchronous to clk.
module hwc_port_wake #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         power_on,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] mask,
    output logic         fall_any
);
    logic [W-1:0] prev;
    logic [W-1:0] fall_bit;

    // Track the previous pin levels, idle-high after power-up.
    always_ff @(posedge clk) begin
        if (power_on)
            prev <= '1;
        else
            prev <= pins;
    end

    // Per-pin masked falling edge.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign fall_bit[i] = prev[i] & ~pins[i] & mask[i];
    end

    assign fall_any = |fall_bit;
endmodule

// File: rtl/hwc_status_flags.sv
// Timeout and sleep status flags.
// Each event input is one cycle wide, and the events are mutually prioritised in
// the order listed in the process below.
module hwc_status_flags (
    input  logic clk,
    input  logic power_on,
    input  logic ev_res_halt,
    input  logic ev_wdt_halt,
    input  logic ev_wdt_run,
    input  logic ev_halt,
    input  logic ev_clr,
    output logic tmo_flag,
    output logic sleep_flag
);
    // Apply the flag rule of the highest-priority event this cycle.
    always_ff @(posedge clk) begin
        if (power_on) begin
            tmo_flag   <= 1'b0;
            sleep_flag <= 1'b0;
        end else if (ev_res_halt) begin
            tmo_flag   <= 1'b0;
            sleep_flag <= 1'b1;
        end else if (ev_wdt_halt) begin
            tmo_flag   <= 1'b1;
            sleep_flag <= 1'b1;
        end else if (ev_wdt_run) begin
            tmo_flag   <= 1'b1;
        end else if (ev_halt) begin
            tmo_flag   <= 1'b0;
            sleep_flag <= 1'b1;
        end else if (ev_clr) begin
            sleep_flag <= 1'b0;
        end
    end

    AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (power_on)
        ev_halt |=> (sleep_flag && !tmo_flag)); // R2
    AST_CLEAR_SLEEP: assert property (@(posedge clk) disable iff (power_on)
        ev_clr |=> !sleep_flag); // R3
    AST_CLEAR_KEEPS_TMO: assert property (@(posedge clk) disable iff (power_on)
        ev_clr |=> (tmo_flag == $past(tmo_flag))); // R3
    AST_RES_HALT_FLAGS: assert property (@(posedge clk) disable iff (power_on)
        ev_res_halt |=> (!tmo_flag && sleep_flag)); // R5
    AST_WDT_SETS_TMO: assert property (@(posedge clk) disable iff (power_on)
        (ev_wdt_run || ev_wdt_halt) |=> tmo_flag); // R6
endmodule

// File: rtl/halt_wake_ctrl.sv
// Halt, wake and restart controller.
// Parks the core on halt_cmd, watches the wake sources, runs a START_DELAY-cycle
// start-up wait after every reset or wake, and picks the resume mode.
// All inputs are assumed synchronous to clk. power_on is the synchronous power-up reset.
module halt_wake_ctrl #(
    parameter int PORT_W      = 8,
    parameter int START_DELAY = 1024
) (
    input  logic              clk,
    input  logic              power_on,
    input  logic              ext_rst_n,
    input  logic              halt_cmd,
    input  logic              wdt_clear_cmd,
    input  logic              wdt_timeout,
    input  logic [PORT_W-1:0] port_pins,
    input  logic [PORT_W-1:0] port_wake_mask,
    input  logic              irq_req,
    input  logic              irq_en,
    input  logic              stack_full,
    output logic              core_run,
    output logic              sys_clk_en,
    output logic              full_reset,
    output logic              warm_reset,
    output logic              take_interrupt,
    output logic              tmo_flag,
    output logic              sleep_flag
);
    import hwc_pkg::*;

    hwc_state_t state;
    rst_kind_t  kind;
    logic       vec_pend;
    logic       ti_q;
    logic       irq_stale;

    logic is_run, is_halt, is_start;
    logic res_evt, wdt_evt, port_fall, irq_wake, wake_soft;
    logic halt_go, clr_go, tmr_load, tmr_done;

    assign is_run   = (state == ST_RUN);
    assign is_halt  = (state == ST_HALT);
    assign is_start = (state == ST_START);

    // Cause decode: reset pin first, then watchdog, then soft wakes and commands.
    assign res_evt   = !ext_rst_n;
    assign wdt_evt   = ext_rst_n && wdt_timeout;
    assign irq_wake  = is_halt && irq_req && !irq_stale;
    assign wake_soft = is_halt && ext_rst_n && !wdt_timeout && (port_fall || irq_wake);
    assign halt_go   = is_run && ext_rst_n && !wdt_timeout && halt_cmd;
    assign clr_go    = is_run && ext_rst_n && !wdt_timeout && !halt_cmd && wdt_clear_cmd;
    assign tmr_load  = res_evt || wdt_evt || wake_soft;

    hwc_port_wake #(.W(PORT_W)) u_port (
        .clk      (clk),
        .power_on (power_on),
        .pins     (port_pins),
        .mask     (port_wake_mask),
        .fall_any (port_fall)
    );

    hwc_startup_timer #(.DELAY(START_DELAY)) u_timer (
        .clk      (clk),
        .power_on (power_on),
        .load     (tmr_load),
        .done     (tmr_done)
    );

    hwc_status_flags u_flags (
        .clk         (clk),
        .power_on    (power_on),
        .ev_res_halt (res_evt && is_halt),
        .ev_wdt_halt (wdt_evt && is_halt),
        .ev_wdt_run  (wdt_evt && !is_halt),
        .ev_halt     (halt_go),
        .ev_clr      (clr_go),
        .tmo_flag    (tmo_flag),
        .sleep_flag  (sleep_flag)
    );

    // Main sequencer: run, halt and start-up wait, with the restart kind and resume mode.
    always_ff @(posedge clk) begin
        if (power_on) begin
            state     <= ST_START;
            kind      <= RK_FULL;
            vec_pend  <= 1'b0;
            ti_q      <= 1'b0;
            irq_stale <= 1'b0;
        end else begin
            ti_q <= 1'b0;
            if (res_evt || (wdt_evt && !is_halt)) begin
                state    <= ST_START;
                kind     <= RK_FULL;
                vec_pend <= 1'b0;
            end else if (wdt_evt) begin
                state    <= ST_START;
                kind     <= RK_WARM;
                vec_pend <= 1'b0;
            end else begin
                case (state)
                    ST_RUN: begin
                        if (halt_go) begin
                            state     <= ST_HALT;
                            irq_stale <= irq_req;
                        end
                    end
                    ST_HALT: begin
                        if (wake_soft) begin
                            state    <= ST_START;
                            kind     <= RK_NONE;
                            vec_pend <= irq_wake && irq_en && !stack_full;
                        end else if (!irq_req) begin
                            irq_stale <= 1'b0;
                        end
                    end
                    ST_START: begin
                        if (tmr_done) begin
                            state    <= ST_RUN;
                            kind     <= RK_NONE;
                            ti_q     <= vec_pend;
                            vec_pend <= 1'b0;
                        end
                    end
                    default: state <= ST_START;
                endcase
            end
        end
    end

    assign core_run       = is_run;
    assign sys_clk_en     = !is_halt;
    assign full_reset     = is_start && (kind == RK_FULL);
    assign warm_reset     = is_start && (kind == RK_WARM);
    assign take_interrupt = ti_q;

    AST_RUN_AFTER_WAIT: assert property (@(posedge clk) disable iff (power_on)
        $rose(core_run) |-> $past(tmr_done)); // R11
    AST_VECTOR_FIRST_RUN: assert property (@(posedge clk) disable iff (power_on)
        take_interrupt |-> (core_run && !$past(core_run))); // R9
    AST_WARM_FLAGS: assert property (@(posedge clk) disable iff (power_on)
        warm_reset |-> (tmo_flag && sleep_flag)); // R7
    AST_STALE_IRQ_SLEEPS: assert property (@(posedge clk) disable iff (power_on)
        (is_halt && irq_stale && ext_rst_n && !wdt_timeout && !port_fall) |=> !core_run); // R10
    AST_RESET_RUN_KEEPS: assert property (@(posedge clk) disable iff (power_on)
        (!ext_rst_n && !is_halt) |=> ($stable(tmo_flag) && $stable(sleep_flag))); // R4
endmodule

// File: tb/halt_wake_ctrl_test.sv
module halt_wake_ctrl_test;
    localparam int W = 4;
    localparam int N = 1024;

    logic clk = 1'b0;
    logic power_on = 1'b1, ext_rst_n = 1'b1, halt_cmd = 1'b0, wdt_clear_cmd = 1'b0;
    logic wdt_timeout = 1'b0, irq_req = 1'b0, irq_en = 1'b0, stack_full = 1'b0;
    logic [W-1:0] port_pins = '1, port_wake_mask = '0;
    logic core_run, sys_clk_en, full_reset, warm_reset, take_interrupt, tmo_flag, sleep_flag;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    halt_wake_ctrl #(.PORT_W(W), .START_DELAY(N)) uut (
        .clk(clk), .power_on(power_on), .ext_rst_n(ext_rst_n), .halt_cmd(halt_cmd),
        .wdt_clear_cmd(wdt_clear_cmd), .wdt_timeout(wdt_timeout), .port_pins(port_pins),
        .port_wake_mask(port_wake_mask), .irq_req(irq_req), .irq_en(irq_en),
        .stack_full(stack_full), .core_run(core_run), .sys_clk_en(sys_clk_en),
        .full_reset(full_reset), .warm_reset(warm_reset), .take_interrupt(take_interrupt),
        .tmo_flag(tmo_flag), .sleep_flag(sleep_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_run(output int n, output int sf, output int sw, output int ti);
        n = 0; sf = 0; sw = 0;
        while (!core_run && n < 3000) begin
            step();
            n++;
            if (full_reset) sf = 1;
            if (warm_reset) sw = 1;
        end
        ti = int'(take_interrupt);
    endtask

    task automatic do_halt();
        halt_cmd = 1'b1; step(); halt_cmd = 1'b0;
    endtask

    task automatic do_wdt();
        wdt_timeout = 1'b1; step(); wdt_timeout = 1'b0;
    endtask

    task automatic do_res();
        ext_rst_n = 1'b0; step(); ext_rst_n = 1'b1;
    endtask

    task automatic do_clr();
        wdt_clear_cmd = 1'b1; step(); wdt_clear_cmd = 1'b0;
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        int n, sf, sw, ti;
        @(negedge clk);
        repeat (3) step();
        // R1 power-up state
        chk("R1 full_reset", int'(full_reset), 1);
        chk("R1 core_run", int'(core_run), 0);
        chk("R1 tmo_flag", int'(tmo_flag), 0);
        chk("R1 sleep_flag", int'(sleep_flag), 0);
        power_on = 1'b0;
        wait_run(n, sf, sw, ti);
        chk("R1 delay", n, N);

        // R8 sweep over every mask and every pin
        for (int m = 0; m < (1 << W); m++) begin
            for (int b = 0; b < W; b++) begin
                port_wake_mask = W'(m);
                do_halt();
                chk("R2 halt core_run", int'(core_run), 0);
                chk("R2 halt sys_clk_en", int'(sys_clk_en), 0);
                chk("R2 halt sleep_flag", int'(sleep_flag), 1);
                chk("R2 halt tmo_flag", int'(tmo_flag), 0);
                port_pins[b] = 1'b0;
                if (((m >> b) & 1) == 1) begin
                    wait_run(n, sf, sw, ti);
                    chk("R8 R11 pin wake delay", n, N + 1);
                    chk("R8 no full_reset", sf, 0);
                    chk("R8 no warm_reset", sw, 0);
                    chk("R8 no vector", ti, 0);
                end else begin
                    repeat (4) step();
                    chk("R8 masked fall core_run", int'(core_run), 0);
                    chk("R8 masked fall sys_clk_en", int'(sys_clk_en), 0);
                    port_pins[b] = 1'b1;
                    repeat (3) step();
                    chk("R8 rising edge core_run", int'(core_run), 0);
                    do_res();
                    chk("R5 full_reset", int'(full_reset), 1);
                    chk("R5 tmo_flag", int'(tmo_flag), 0);
                    chk("R5 sleep_flag", int'(sleep_flag), 1);
                    wait_run(n, sf, sw, ti);
                    chk("R5 delay", n, N);
                end
                port_pins = '1;
                step();
            end
        end

        // R6 watchdog in run with sleep_flag=1
        do_wdt();
        chk("R6 full_reset", int'(full_reset), 1);
        chk("R6 warm_reset", int'(warm_reset), 0);
        chk("R6 tmo_flag", int'(tmo_flag), 1);
        chk("R6 sleep_flag kept 1", int'(sleep_flag), 1);
        wait_run(n, sf, sw, ti);
        chk("R6 delay", n, N);

        // R3 clear in run
        do_clr();
        chk("R3 sleep_flag", int'(sleep_flag), 0);
        chk("R3 tmo_flag kept", int'(tmo_flag), 1);

        // R6 watchdog in run with sleep_flag=0
        do_wdt();
        chk("R6 tmo_flag b", int'(tmo_flag), 1);
        chk("R6 sleep_flag kept 0", int'(sleep_flag), 0);
        wait_run(n, sf, sw, ti);

        // R4 reset in run, flags 1/0 kept, held several cycles
        ext_rst_n = 1'b0;
        repeat (5) step();
        chk("R4 full_reset", int'(full_reset), 1);
        chk("R4 core_run", int'(core_run), 0);
        ext_rst_n = 1'b1;
        chk("R4 tmo_flag kept", int'(tmo_flag), 1);
        chk("R4 sleep_flag kept", int'(sleep_flag), 0);
        wait_run(n, sf, sw, ti);
        chk("R4 delay", n, N);

        // R11 reset during the wait reloads it
        do_res();
        repeat (200) step();
        chk("R11 still waiting", int'(core_run), 0);
        do_res();
        wait_run(n, sf, sw, ti);
        chk("R11 reload delay", n, N);

        // R7 watchdog during halt
        do_halt();
        do_wdt();
        chk("R7 warm_reset", int'(warm_reset), 1);
        chk("R7 full_reset", int'(full_reset), 0);
        chk("R7 tmo_flag", int'(tmo_flag), 1);
        chk("R7 sleep_flag", int'(sleep_flag), 1);
        wait_run(n, sf, sw, ti);
        chk("R7 delay", n, N);
        chk("R7 never full", sf, 0);
        chk("R7 vector", ti, 0);

        // R9 interrupt wake: enable and stack combinations
        port_wake_mask = '0;
        for (int c = 0; c < 4; c++) begin
            irq_en = c[0];
            stack_full = c[1];
            do_halt();
            irq_req = 1'b1;
            wait_run(n, sf, sw, ti);
            chk("R9 irq wake delay", n, N + 1);
            chk("R9 take_interrupt", ti, (c[0] && !c[1]) ? 1 : 0);
            step();
            chk("R9 pulse one cycle", int'(take_interrupt), 0);
            irq_req = 1'b0;
            step();
        end

        // R10 request already pending at halt entry
        irq_en = 1'b0;
        stack_full = 1'b0;
        irq_req = 1'b1;
        step();
        do_halt();
        repeat (20) step();
        chk("R10 no wake", int'(core_run), 0);
        irq_req = 1'b0;
        step();
        irq_req = 1'b1;
        wait_run(n, sf, sw, ti);
        chk("R10 fresh request wakes", n, N + 1);
        irq_req = 1'b0;

        done_flag = 1'b1;
        report();
        $finish;
    end
endmodule